// File: doc/BRIEF.md
# Slot Mailbox with Control/Status Words

This block is a two-way mailbox between a host and a peer agent. Each direction uses a circular buffer of 32-bit slots. The host reaches the block through four word registers. It pushes slots toward the peer through a write window and pops slots that came from the peer through a read window. It sees the state of each buffer as a packed status word holding its read pointer, its write pointer and its depth. The peer has a simple streaming port on each buffer, a pulse that tells the block it is ready, and a pulse that raises an interrupt toward the host.

Each pointer is an 8-bit counter that wraps modulo 256. Software finds the occupancy as the write pointer minus the read pointer, modulo 256. It finds the free space as the depth field minus that occupancy. A reset bit in the host status word flushes both buffers and withdraws the peer's ready flag. The host may push into its buffer only after the peer has signalled ready again.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset both status words read 0x08000000 with the default depth of 8. The depth sits in bits 31:24 and every other field is zero. host_irq, host_ready and host_doorbell are 0.
- R2: The address map uses word offsets: 0x0 is the host-to-peer write window, 0x4 the host status word, 0x8 the peer-to-host read window and 0xC the peer status word. In both status words bits 15:8 hold the read pointer, bits 23:16 the write pointer and bits 31:24 the depth. Bit 3 of the peer status word is the peer ready flag. Read data appears on host_rdata one cycle after the read strobe.
- R3: Each accepted write to the write window stores one slot and advances the host-side write pointer. The peer pops the slots on peer_rdata in the order they were written.
- R4: Each peer_push stores one slot and advances the peer-side write pointer. Each read of the read window returns the oldest slot and advances the peer-side read pointer.
- R5: The pointers wrap from 255 to 0. The occupancy (write pointer minus read pointer, modulo 256) stays correct across the wrap and never exceeds the depth.
- R6: A window write while the host-side buffer holds depth slots is dropped. The write pointer does not move, and the sticky overflow flag at host status bit 5 becomes 1.
- R7: A read of the read window while the peer-side buffer is empty returns 0 and leaves the read pointer unchanged.
- R8: Host status bit 1 (interrupt status) is set by a peer_irq_gen pulse. Writing 1 to it clears it. Writing 0 to it leaves it unchanged.
- R9: host_irq is 1 exactly when host status bit 0 (interrupt enable) and bit 1 are both 1.
- R10: Writing 1 to host status bit 2 (interrupt generate) drives host_doorbell high for one cycle. The bit reads back as 0.
- R11: Writing 1 to host status bit 4 (reset) clears both buffers' pointers, the overflow flag and the peer ready flag. While the bit stays 1, window writes and peer pushes are dropped.
- R12: A window write while the peer ready flag is 0 is dropped and does not set the overflow flag. The flag is set by a peer_ready_set pulse while the reset bit is 0.
- R13: Host status bit 3 (host ready) is read/write and drives the host_ready output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host byte address; bits 3:2 select the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Interrupt to the host |
| host_ready | output | 1 | Host ready flag toward the peer |
| host_doorbell | output | 1 | One-cycle interrupt pulse toward the peer |
| peer_ready_set | input | 1 | Peer announces it is ready |
| peer_irq_gen | input | 1 | Peer raises the host interrupt status |
| peer_pop | input | 1 | Peer takes the head slot of the host-to-peer buffer |
| peer_rdata | output | 32 | Head slot of the host-to-peer buffer |
| peer_empty | output | 1 | Host-to-peer buffer is empty |
| peer_push | input | 1 | Peer stores a slot into the peer-to-host buffer |
| peer_wdata | input | 32 | Slot data from the peer |
| peer_full | output | 1 | Peer-to-host buffer is full |

## Verification
The bound checker checks four things on every cycle: the host-side occupancy never exceeds the depth, a flush zeroes every pointer and the peer ready flag, a write into a full buffer leaves the pointer still and raises overflow, and a read of an empty buffer never moves its pointer. It also checks that a peer interrupt pulse always sets the status bit and that a cleared enable keeps host_irq low. Only the bench scenarios can show that data comes out in order through a wrap of the 8-bit pointers. The same holds for the exact packed status words, the write-1-to-clear behaviour, the single-cycle doorbell and the ready handshake needed after a flush.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int SLOT_W = 32;
   localparam int PTR_W  = 8;

   // register select, host_addr[3:2]
   localparam logic [1:0] SEL_WIN_WR   = 2'd0;
   localparam logic [1:0] SEL_HOST_CSR = 2'd1;
   localparam logic [1:0] SEL_WIN_RD   = 2'd2;
   localparam logic [1:0] SEL_PEER_CSR = 2'd3;

   // status word bit positions
   localparam int B_IE    = 0;
   localparam int B_IS    = 1;
   localparam int B_IG    = 2;
   localparam int B_RDY   = 3;
   localparam int B_RST   = 4;
   localparam int B_OVF   = 5;
   localparam int F_RP    = 8;
   localparam int F_WP    = 16;
   localparam int F_DEPTH = 24;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [PTR_W-1:0]  wp,
   output logic [PTR_W-1:0]  rp,
   output logic              full,
   output logic              empty
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  fill;
   logic              push_ok;
   logic              pop_ok;

   assign fill    = wp - rp;
   assign full    = (fill == PTR_W'(DEPTH));
   assign empty   = (fill == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign head    = mem[rp[IDX_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp[IDX_W-1:0]] <= wdata;
   end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic csr_wr,
   input  logic wd_ie,
   input  logic wd_is,
   input  logic set_req,
   output logic ie,
   output logic is,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie <= 1'b0;
         is <= 1'b0;
      end else begin
         if (csr_wr) ie <= wd_ie;
         if (set_req)
            is <= 1'b1;
         else if (csr_wr && wd_is)
            is <= 1'b0;
      end
   end

   assign irq = ie && is;
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
   import mbx_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic              host_rd_en,
   input  logic [3:0]        host_addr,
   input  logic [SLOT_W-1:0] host_wdata,
   output logic [SLOT_W-1:0] host_rdata,
   output logic              host_irq,
   output logic              host_ready,
   output logic              host_doorbell,
   input  logic              peer_ready_set,
   input  logic              peer_irq_gen,
   input  logic              peer_pop,
   output logic [SLOT_W-1:0] peer_rdata,
   output logic              peer_empty,
   input  logic              peer_push,
   input  logic [SLOT_W-1:0] peer_wdata,
   output logic              peer_full
);
   localparam logic [PTR_W-1:0] DEPTH_F = PTR_W'(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mbx_mailbox: DEPTH must be a power of two from 2 to 128");
      end
   endgenerate

   logic [1:0]       sel;
   logic             aligned;
   logic             wr_win, wr_csr, rd_win;
   logic             flush, win_ok;
   logic             rst_q, hrdy_q, peer_rdy_q, ovf_q;
   logic             irq_ie, irq_is;
   logic [PTR_W-1:0] h2p_wp, h2p_rp, p2h_wp, p2h_rp;
   logic             h2p_full, p2h_empty;
   logic [SLOT_W-1:0] p2h_head;
   logic [SLOT_W-1:0] host_csr, peer_csr;

   assign sel     = host_addr[3:2];
   assign aligned = (host_addr[1:0] == 2'b00);
   assign wr_win  = host_wr_en && aligned && (sel == SEL_WIN_WR);
   assign wr_csr  = host_wr_en && aligned && (sel == SEL_HOST_CSR);
   assign rd_win  = host_rd_en && aligned && (sel == SEL_WIN_RD);
   assign flush   = rst_q || (wr_csr && host_wdata[B_RST]);
   assign win_ok  = wr_win && peer_rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q         <= 1'b0;
         hrdy_q        <= 1'b0;
         host_doorbell <= 1'b0;
      end else begin
         host_doorbell <= wr_csr && host_wdata[B_IG];
         if (wr_csr) begin
            rst_q  <= host_wdata[B_RST];
            hrdy_q <= host_wdata[B_RDY];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peer_rdy_q <= 1'b0;
         ovf_q      <= 1'b0;
      end else begin
         if (flush)               peer_rdy_q <= 1'b0;
         else if (peer_ready_set) peer_rdy_q <= 1'b1;
         if (flush)                 ovf_q <= 1'b0;
         else if (win_ok && h2p_full) ovf_q <= 1'b1;
      end
   end

   mbx_ring #(.DEPTH(DEPTH), .DATA_W(SLOT_W), .PTR_W(PTR_W)) u_h2p (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(win_ok), .wdata(host_wdata), .pop(peer_pop),
      .head(peer_rdata), .wp(h2p_wp), .rp(h2p_rp),
      .full(h2p_full), .empty(peer_empty)
   );

   mbx_ring #(.DEPTH(DEPTH), .DATA_W(SLOT_W), .PTR_W(PTR_W)) u_p2h (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(peer_push), .wdata(peer_wdata), .pop(rd_win),
      .head(p2h_head), .wp(p2h_wp), .rp(p2h_rp),
      .full(peer_full), .empty(p2h_empty)
   );

   mbx_irq u_irq (
      .clk(clk), .rst_n(rst_n), .csr_wr(wr_csr),
      .wd_ie(host_wdata[B_IE]), .wd_is(host_wdata[B_IS]),
      .set_req(peer_irq_gen), .ie(irq_ie), .is(irq_is), .irq(host_irq)
   );

   always_comb begin
      host_csr                   = '0;
      host_csr[B_IE]             = irq_ie;
      host_csr[B_IS]             = irq_is;
      host_csr[B_RDY]            = hrdy_q;
      host_csr[B_RST]            = rst_q;
      host_csr[B_OVF]            = ovf_q;
      host_csr[F_RP +: PTR_W]    = h2p_rp;
      host_csr[F_WP +: PTR_W]    = h2p_wp;
      host_csr[F_DEPTH +: PTR_W] = DEPTH_F;
      peer_csr                   = '0;
      peer_csr[B_RDY]            = peer_rdy_q;
      peer_csr[F_RP +: PTR_W]    = p2h_rp;
      peer_csr[F_WP +: PTR_W]    = p2h_wp;
      peer_csr[F_DEPTH +: PTR_W] = DEPTH_F;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd_en) begin
         if (!aligned)
            host_rdata <= '0;
         else begin
            case (sel)
               SEL_HOST_CSR: host_rdata <= host_csr;
               SEL_WIN_RD:   host_rdata <= p2h_empty ? '0 : p2h_head;
               SEL_PEER_CSR: host_rdata <= peer_csr;
               default:      host_rdata <= '0;
            endcase
         end
      end
   end

   assign host_ready = hrdy_q;
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
   parameter int DEPTH = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       flush,
   input logic       win_ok,
   input logic       rd_win,
   input logic       peer_irq_gen,
   input logic       host_irq,
   input logic       irq_ie,
   input logic       irq_is,
   input logic       peer_rdy_q,
   input logic       ovf_q,
   input logic [7:0] h2p_wp,
   input logic [7:0] h2p_rp,
   input logic [7:0] p2h_wp,
   input logic [7:0] p2h_rp
);
   logic [7:0] h2p_fill;
   assign h2p_fill = h2p_wp - h2p_rp;

   a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      h2p_fill <= 8'(DEPTH));

   a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (h2p_wp == 8'd0 && h2p_rp == 8'd0 && p2h_wp == 8'd0
                 && p2h_rp == 8'd0 && !peer_rdy_q && !ovf_q));

   a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (win_ok && !flush && h2p_fill == 8'(DEPTH)) |=> ($stable(h2p_wp) && ovf_q));

   a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win && !flush && p2h_wp == p2h_rp) |=> $stable(p2h_rp));

   a_r8_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      peer_irq_gen |=> irq_is);

   a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_ie |-> !host_irq);
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/mbx_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_mailbox_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        host_irq, host_ready, host_doorbell;
   logic        peer_ready_set = 1'b0, peer_irq_gen = 1'b0;
   logic        peer_pop = 1'b0, peer_push = 1'b0;
   logic [31:0] peer_rdata, peer_wdata = '0;
   logic        peer_empty, peer_full;

   int n_chk = 0, n_bad = 0;
   logic [31:0] sb_q[$];
   logic [31:0] rd;

   always #5 clk = ~clk;

   mbx_mailbox u_dut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [3:0] a, input logic [31:0] d);
      host_addr = a; host_wdata = d; host_wr_en = 1'b1;
      @(posedge clk); #1 host_wr_en = 1'b0;
   endtask

   task automatic host_read(input logic [3:0] a, output logic [31:0] d);
      host_addr = a; host_rd_en = 1'b1;
      @(posedge clk); #1 host_rd_en = 1'b0;
      d = host_rdata;
   endtask

   task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string req);
      logic [31:0] v;
      host_read(a, v);
      check(v == exp, req, v, exp);
   endtask

   // driver: pushes a slot and records it in the scoreboard when it should land
   task automatic drv_push(input logic [31:0] d, input bit accept);
      host_write(4'h0, d);
      if (accept) sb_q.push_back(d);
   endtask

   task automatic peer_take(input int n);
      peer_pop = 1'b1;
      repeat (n) @(posedge clk);
      #1 peer_pop = 1'b0;
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; @(posedge clk); #1 s = 1'b0;
   endtask

   // monitor: compares each slot the peer takes against the scoreboard (R3)
   always @(negedge clk) begin
      if (rst_n && peer_pop) begin
         if (sb_q.size() == 0)
            check(1'b0, "R3 unexpected pop", peer_rdata, 32'h0);
         else begin
            logic [31:0] e;
            e = sb_q.pop_front();
            check(!peer_empty && peer_rdata == e, "R3 slot order", peer_rdata, e);
         end
      end
   end

   initial begin
      #2_000_000;
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      check(!host_irq && !host_ready && !host_doorbell, "R1 outputs", {29'd0, host_irq, host_ready, host_doorbell}, 32'h0);
      expect_reg(4'h4, 32'h0800_0000, "R1 host status");
      expect_reg(4'hC, 32'h0800_0000, "R1 peer status");
      // R13 host ready bit
      host_write(4'h4, 32'h08);
      check(host_ready == 1'b1, "R13 host_ready", {31'd0, host_ready}, 32'h1);
      expect_reg(4'h4, 32'h0800_0008, "R13 readback");
      // R12 dropped while peer not ready
      drv_push(32'hDEAD_0001, 1'b0);
      expect_reg(4'h4, 32'h0800_0008, "R12 no push no overflow");
      pulse(peer_ready_set);
      expect_reg(4'hC, 32'h0800_0008, "R12 peer ready flag");
      // R3 R2 basic traffic
      for (int i = 0; i < 3; i++) drv_push(32'hA000_0000 + i, 1'b1);
      expect_reg(4'h4, 32'h0803_0008, "R2 write pointer field");
      peer_take(3);
      expect_reg(4'h4, 32'h0803_0308, "R3 read pointer field");
      // R6 full buffer
      for (int i = 0; i < 8; i++) drv_push(32'hB000_0000 + i, 1'b1);
      drv_push(32'hBAD0_BAD0, 1'b0);
      expect_reg(4'h4, 32'h080B_0328, "R6 overflow and stalled pointer");
      peer_take(8);
      // R5 wrap of pointers
      for (int i = 0; i < 243; i++) begin
         drv_push(32'hC000_0000 + i, 1'b1);
         peer_take(1);
      end
      expect_reg(4'h4, 32'h08FE_FE28, "R5 pointers at 254");
      for (int i = 0; i < 4; i++) drv_push(32'hD000_0000 + i, 1'b1);
      expect_reg(4'h4, 32'h0802_FE28, "R5 wrapped write pointer");
      for (int i = 0; i < 4; i++) drv_push(32'hD100_0000 + i, 1'b1);
      drv_push(32'hBAD1_BAD1, 1'b0);
      expect_reg(4'h4, 32'h0806_FE28, "R5 R6 full across wrap");
      peer_take(8);
      expect_reg(4'h4, 32'h0806_0628, "R5 drained");
      check(sb_q.size() == 0, "R3 scoreboard empty", sb_q.size(), 32'h0);
      // R4 peer to host
      peer_wdata = 32'h1111_2222; peer_push = 1'b1;
      @(posedge clk); #1 peer_wdata = 32'h3333_4444;
      @(posedge clk); #1 peer_push = 1'b0;
      expect_reg(4'hC, 32'h0802_0008, "R4 peer write pointer");
      expect_reg(4'h8, 32'h1111_2222, "R4 first slot");
      expect_reg(4'h8, 32'h3333_4444, "R4 second slot");
      // R7 empty read
      expect_reg(4'h8, 32'h0, "R7 empty read value");
      expect_reg(4'hC, 32'h0802_0208, "R7 pointer unchanged");
      // R8 R9 interrupt
      host_write(4'h4, 32'h09);
      check(!host_irq, "R9 no status", {31'd0, host_irq}, 32'h0);
      pulse(peer_irq_gen);
      check(host_irq, "R9 irq asserted", {31'd0, host_irq}, 32'h1);
      expect_reg(4'h4, 32'h0806_062B, "R8 status set");
      host_write(4'h4, 32'h09);
      check(host_irq, "R8 write 0 keeps status", {31'd0, host_irq}, 32'h1);
      host_write(4'h4, 32'h0B);
      check(!host_irq, "R8 write 1 clears", {31'd0, host_irq}, 32'h0);
      pulse(peer_irq_gen);
      host_write(4'h4, 32'h08);
      check(!host_irq, "R9 masked", {31'd0, host_irq}, 32'h0);
      expect_reg(4'h4, 32'h0806_062A, "R9 status kept while masked");
      // R10 doorbell
      host_addr = 4'h4; host_wdata = 32'h0C; host_wr_en = 1'b1;
      @(posedge clk); #1 host_wr_en = 1'b0;
      check(host_doorbell, "R10 doorbell high", {31'd0, host_doorbell}, 32'h1);
      @(posedge clk); #1;
      check(!host_doorbell, "R10 doorbell one cycle", {31'd0, host_doorbell}, 32'h0);
      expect_reg(4'h4, 32'h0806_062A, "R10 reads as zero");
      // R11 reset handshake
      drv_push(32'hE000_0001, 1'b0);
      drv_push(32'hE000_0002, 1'b0);
      host_write(4'h4, 32'h18);
      sb_q.delete();
      expect_reg(4'h4, 32'h0800_001A, "R11 host side flushed");
      expect_reg(4'hC, 32'h0800_0000, "R11 peer ready cleared");
      check(peer_empty, "R11 peer sees empty", {31'd0, peer_empty}, 32'h1);
      pulse(peer_ready_set);
      drv_push(32'hE000_0003, 1'b0);
      pulse(peer_push);
      expect_reg(4'h4, 32'h0800_001A, "R11 writes dropped in reset");
      expect_reg(4'hC, 32'h0800_0000, "R11 peer push dropped in reset");
      host_write(4'h4, 32'h08);
      drv_push(32'hE000_0004, 1'b0);
      expect_reg(4'h4, 32'h0800_000A, "R12 dropped until ready again");
      pulse(peer_ready_set);
      drv_push(32'hF000_0005, 1'b1);
      expect_reg(4'h4, 32'h0801_000A, "R11 channel restored");
      peer_take(1);
      check(sb_q.size() == 0, "R3 final scoreboard", sb_q.size(), 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule